// File: doc/BRIEF.md
# Strip-Scan Windowed Correlator

This block slides a small signed coefficient template across an image and produces one correlation sum for each window position that lies wholly inside the image. Pixels arrive on a valid/ready stream, one per accepted cycle. The producer delivers them in vertical strips: each strip is `W+K-1` columns wide, and consecutive strips start `W` columns apart. Within a strip the rows run downward on even strips and upward on odd strips. Each row inside a strip is delivered left to right.

The block keeps only the last `K` rows of the current strip on chip. It never holds a full image line. Each time a strip row completes, and at least `K` rows of that strip have arrived, the block emits the `sw-K+1` results for that row's window band (`sw` is the strip's clipped width) on a valid/ready result stream. Each result is tagged with its top-left window coordinate. Raising `W` widens the strip, which means fewer re-fetched overlap columns and more results per row, at the cost of more buffer storage.

A signed partial sum on `cas_in` is added to every result. This lets several instances that cover parts of a larger template be summed in a chain. The image size is latched from the ports on `start`. Coefficients are written through a small write port while the block is idle.

Top module: `zz_convolver`

## Requirements
- R1: While reset is held and in the first cycle after it, `in_ready` and `out_valid` are both 0.
- R2: A `start` pulse in the idle state latches `img_w`/`img_h` (each at least K) and raises `in_ready` in the next cycle.
- R3: The pixel order expected is strip s (column base s*W, width min(W+K-1, img_w-s*W)), for every s with s*W <= img_w-K. Even strips run rows 0 to img_h-1 and odd strips run rows img_h-1 down to 0. Each row runs left to right. Exactly that many pixels are accepted per frame.
- R4: `out_sum` equals the sum over i,j in 0..K-1 of coef[i*K+j] * pixel(out_x+j, out_y+i), plus `cas_in`. Here coef is signed 8-bit at address i*K+j, and pixel is unsigned. The sum is taken at full precision and sign-extended to RES_W bits.
- R5: Results are emitted only for out_x <= img_w-K and out_y <= img_h-K, and each such position exactly once. For each strip row they come in ascending out_x. The row order is ascending out_y on even strips and descending on odd strips.
- R6: `in_ready` and `out_valid` are never 1 in the same cycle.
- R7: While `out_valid` is 1 and `out_ready` is 0, the next cycle keeps `out_valid`, `out_x` and `out_y` unchanged.
- R8: A coefficient write while a frame is in progress has no effect on the results of that frame.
- R9: A `start` pulse while a frame is in progress is ignored and does not change the latched image size.
- R10: After the last result of a frame is taken, the block is idle (`in_ready`=0, `out_valid`=0) and accepts a new `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a frame (idle only) |
| img_w | input | DIM_W | Image width in pixels |
| img_h | input | DIM_W | Image height in pixels |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | CA_W | Coefficient index i*K+j |
| coef_data | input | COEF_W | Signed coefficient value |
| in_valid | input | 1 | Pixel stream valid |
| in_ready | output | 1 | Pixel stream ready |
| in_pix | input | PIX_W | Unsigned pixel |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result ready |
| out_sum | output | RES_W | Signed correlation sum plus cascade input |
| out_x | output | DIM_W | Window left column |
| out_y | output | DIM_W | Window top row |
| cas_in | input | RES_W | Signed partial sum from an upstream instance |

## Verification
The hardest case to reach is the turn at a strip boundary. There the row direction flips, the row buffer restarts with a stale slot pointer, and the last strip may be clipped narrower than W+K-1. The stimulus reaches it by sweeping image widths that give one, two and three strips, including exact-fit and clipped last strips, and heights from K upward. Both streams carry irregular stall patterns throughout. A frame with mid-run coefficient writes and a stray start pulse exercises the busy-state guards. An all-extreme frame drives the accumulator to its most negative value.

// File: rtl/zzconv_pkg.sv
package zzconv_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_FILL = 2'd1,
      ST_EMIT = 2'd2
   } zz_state_e;
endpackage

// File: rtl/zz_coef_bank.sv
module zz_coef_bank #(
   parameter int NTAP   = 9,
   parameter int COEF_W = 8,
   localparam int CA_W  = $clog2(NTAP)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we,
   input  logic [CA_W-1:0]          addr,
   input  logic [COEF_W-1:0]        data,
   output logic [NTAP*COEF_W-1:0]   taps
);
   logic [COEF_W-1:0] bank [NTAP];

   for (genvar t = 0; t < NTAP; t++) begin : g_tap
      always_ff @(posedge clk) begin
         if (!rst_n)
            bank[t] <= '0;
         else if (we && (int'(addr) == t))
            bank[t] <= data;
      end
      assign taps[t*COEF_W +: COEF_W] = bank[t];
   end
endmodule

// File: rtl/zz_strip_buf.sv
module zz_strip_buf #(
   parameter int K     = 3,
   parameter int SPAN  = 6,
   parameter int PIX_W = 8,
   localparam int SL_W = $clog2(K),
   localparam int CW   = (SPAN > 1) ? $clog2(SPAN) : 1
) (
   input  logic                     clk,
   input  logic                     we,
   input  logic [SL_W-1:0]          wslot,
   input  logic [CW-1:0]            wcol,
   input  logic [PIX_W-1:0]         wdata,
   input  logic [K*SL_W-1:0]        rslot,
   input  logic [CW-1:0]            rcol,
   output logic [K*K*PIX_W-1:0]     win
);
   logic [PIX_W-1:0] mem [K][SPAN];

   always_ff @(posedge clk) begin
      if (we)
         mem[wslot][wcol] <= wdata;
   end

   for (genvar gi = 0; gi < K; gi++) begin : g_row
      for (genvar gj = 0; gj < K; gj++) begin : g_col
         always_comb begin
            int idx;
            idx = int'(rcol) + gj;
            win[(gi*K+gj)*PIX_W +: PIX_W] = '0;
            if (idx < SPAN)
               win[(gi*K+gj)*PIX_W +: PIX_W] = mem[rslot[gi*SL_W +: SL_W]][idx];
         end
      end
   end
endmodule

// File: rtl/zz_mac_tree.sv
module zz_mac_tree #(
   parameter int NTAP   = 9,
   parameter int PIX_W  = 8,
   parameter int COEF_W = 8,
   parameter int ACC_W  = 20
) (
   input  logic [NTAP*PIX_W-1:0]    win,
   input  logic [NTAP*COEF_W-1:0]   taps,
   output logic signed [ACC_W-1:0]  acc
);
   logic signed [ACC_W-1:0] prod [NTAP];

   for (genvar t = 0; t < NTAP; t++) begin : g_prod
      logic signed [PIX_W:0]    px;
      logic signed [COEF_W-1:0] cf;
      logic signed [ACC_W-1:0]  pe, ce;
      always_comb begin
         px = {1'b0, win[t*PIX_W +: PIX_W]};
         cf = taps[t*COEF_W +: COEF_W];
         pe = ACC_W'(px);
         ce = ACC_W'(cf);
         prod[t] = pe * ce;
      end
   end

   always_comb begin
      acc = '0;
      for (int t = 0; t < NTAP; t++)
         acc = acc + prod[t];
   end
endmodule

// File: rtl/zz_convolver.sv
module zz_convolver
   import zzconv_pkg::*;
#(
   parameter int K      = 3,
   parameter int W      = 4,
   parameter int PIX_W  = 8,
   parameter int COEF_W = 8,
   parameter int DIM_W  = 10,
   parameter int RES_W  = 24,
   localparam int NTAP  = K*K,
   localparam int CA_W  = $clog2(NTAP)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [DIM_W-1:0]   img_w,
   input  logic [DIM_W-1:0]   img_h,
   input  logic               coef_we,
   input  logic [CA_W-1:0]    coef_addr,
   input  logic [COEF_W-1:0]  coef_data,
   input  logic               in_valid,
   output logic               in_ready,
   input  logic [PIX_W-1:0]   in_pix,
   output logic               out_valid,
   input  logic               out_ready,
   output logic [RES_W-1:0]   out_sum,
   output logic [DIM_W-1:0]   out_x,
   output logic [DIM_W-1:0]   out_y,
   input  logic [RES_W-1:0]   cas_in
);
   localparam int SPAN  = W + K - 1;
   localparam int CW    = (SPAN > 1) ? $clog2(SPAN) : 1;
   localparam int SL_W  = $clog2(K);
   localparam int ACC_W = PIX_W + COEF_W + $clog2(NTAP);

   if (K < 2 || W < 1 || DIM_W < 2 || RES_W < ACC_W || SPAN >= (1 << DIM_W)) begin : g_bad_cfg
      $error("zz_convolver: unsupported parameter set");
   end

   zz_state_e             state;
   logic [DIM_W-1:0]      w_q, h_q, s_base, rcnt, rcnt_nx, sw, rem;
   logic [CW-1:0]         ccol, oc;
   logic [SL_W-1:0]       wp, wp_nx;
   logic                  dir_up, row_end, oc_end, more_strips;
   logic [K*SL_W-1:0]     rslot;
   logic [NTAP*PIX_W-1:0] win;
   logic [NTAP*COEF_W-1:0] taps;
   logic signed [ACC_W-1:0] acc;

   always_comb begin
      rem         = w_q - s_base;
      sw          = (rem > DIM_W'(SPAN)) ? DIM_W'(SPAN) : rem;
      row_end     = (DIM_W'(ccol) == sw - 1'b1);
      oc_end      = (DIM_W'(oc) == sw - DIM_W'(K));
      more_strips = ({1'b0, s_base} + (DIM_W+1)'(W + K)) <= {1'b0, w_q};
      wp_nx       = (wp == SL_W'(K-1)) ? '0 : wp + 1'b1;
      rcnt_nx     = rcnt + 1'b1;
   end

   // window row i takes the slot written (K-1-i) rows ago going down, i rows ago going up
   always_comb begin
      for (int i = 0; i < K; i++) begin
         int age, v;
         age = dir_up ? i : (K - 1 - i);
         v   = int'(wp) + K - 1 - age;
         if (v >= K) v = v - K;
         rslot[i*SL_W +: SL_W] = SL_W'(v);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         w_q    <= '0;
         h_q    <= '0;
         s_base <= '0;
         rcnt   <= '0;
         ccol   <= '0;
         oc     <= '0;
         wp     <= '0;
         dir_up <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: if (start) begin
               w_q    <= img_w;
               h_q    <= img_h;
               s_base <= '0;
               rcnt   <= '0;
               ccol   <= '0;
               wp     <= '0;
               dir_up <= 1'b0;
               state  <= ST_FILL;
            end
            ST_FILL: if (in_valid) begin
               if (row_end) begin
                  ccol <= '0;
                  wp   <= wp_nx;
                  rcnt <= rcnt_nx;
                  if (rcnt_nx >= DIM_W'(K)) begin
                     oc    <= '0;
                     state <= ST_EMIT;
                  end
               end else begin
                  ccol <= ccol + 1'b1;
               end
            end
            ST_EMIT: if (out_ready) begin
               if (oc_end) begin
                  if (rcnt == h_q) begin
                     if (more_strips) begin
                        s_base <= s_base + DIM_W'(W);
                        dir_up <= ~dir_up;
                        rcnt   <= '0;
                        wp     <= '0;
                        ccol   <= '0;
                        state  <= ST_FILL;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end else begin
                     state <= ST_FILL;
                  end
               end else begin
                  oc <= oc + 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   zz_coef_bank #(.NTAP(NTAP), .COEF_W(COEF_W)) u_coef (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (coef_we && (state == ST_IDLE)),
      .addr (coef_addr),
      .data (coef_data),
      .taps (taps)
   );

   zz_strip_buf #(.K(K), .SPAN(SPAN), .PIX_W(PIX_W)) u_buf (
      .clk  (clk),
      .we   ((state == ST_FILL) && in_valid),
      .wslot(wp),
      .wcol (ccol),
      .wdata(in_pix),
      .rslot(rslot),
      .rcol (oc),
      .win  (win)
   );

   zz_mac_tree #(.NTAP(NTAP), .PIX_W(PIX_W), .COEF_W(COEF_W), .ACC_W(ACC_W)) u_mac (
      .win (win),
      .taps(taps),
      .acc (acc)
   );

   assign in_ready  = (state == ST_FILL);
   assign out_valid = (state == ST_EMIT);
   assign out_x     = s_base + DIM_W'(oc);
   assign out_y     = dir_up ? (h_q - rcnt) : (rcnt - DIM_W'(K));
   assign out_sum   = RES_W'(acc) + cas_in;
endmodule

// File: rtl/zz_convolver_chk.sv
module zz_convolver_chk #(
   parameter int K     = 3,
   parameter int DIM_W = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             idle,
   input logic             in_ready,
   input logic             out_valid,
   input logic             out_ready,
   input logic [DIM_W-1:0] out_x,
   input logic [DIM_W-1:0] out_y,
   input logic [DIM_W-1:0] w_q,
   input logic [DIM_W-1:0] h_q
);
   p_start_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start && idle |=> in_ready);

   p_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (({1'b0, out_x} + (DIM_W+1)'(K)) <= {1'b0, w_q}) &&
                    (({1'b0, out_y} + (DIM_W+1)'(K)) <= {1'b0, h_q}));

   p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_ready && out_valid));

   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_x) && $stable(out_y));

   p_busy_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
      start && !idle |=> $stable(w_q) && $stable(h_q));
endmodule

bind zz_convolver zz_convolver_chk #(.K(K), .DIM_W(DIM_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .idle     (state == zzconv_pkg::ST_IDLE),
   .in_ready (in_ready),
   .out_valid(out_valid),
   .out_ready(out_ready),
   .out_x    (out_x),
   .out_y    (out_y),
   .w_q      (w_q),
   .h_q      (h_q)
);

// File: tb/zz_convolver_tb_top.sv
module zz_convolver_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int K = 3, W = 4, DIM_W = 10, RES_W = 24;

   logic clk = 0, rst_n = 0, start = 0, coef_we = 0;
   logic [DIM_W-1:0] img_w = 0, img_h = 0;
   logic [3:0] coef_addr = 0;
   logic [7:0] coef_data = 0, in_pix = 0;
   logic in_valid = 0, in_ready, out_valid, out_ready = 0;
   logic [RES_W-1:0] out_sum, cas_in = 0;
   logic [DIM_W-1:0] out_x, out_y;

   int n_tests = 0, n_fail = 0, cyc = 0;
   int coefs [K*K];

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   zz_convolver #(.K(K), .W(W), .DIM_W(DIM_W), .RES_W(RES_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .img_w(img_w), .img_h(img_h),
      .coef_we(coef_we), .coef_addr(coef_addr), .coef_data(coef_data),
      .in_valid(in_valid), .in_ready(in_ready), .in_pix(in_pix),
      .out_valid(out_valid), .out_ready(out_ready), .out_sum(out_sum),
      .out_x(out_x), .out_y(out_y), .cas_in(cas_in)
   );

   function automatic int pixv(int x, int y, int seed, int mode);
      if (mode == 1) return 255;
      return (x*37 + y*91 + seed*13 + x*y*5) & 255;
   endfunction

   function automatic int coefv(int k, int seed, int mode);
      if (mode == 1) return -128;
      return ((k*53 + seed*29) % 256) - 128;
   endfunction

   task automatic check(bit ok, string req, int act, int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic load_coefs(int seed, int mode);
      for (int k = 0; k < K*K; k++) begin
         coefs[k] = coefv(k, seed, mode);
         @(negedge clk);
         coef_we = 1; coef_addr = 4'(k); coef_data = 8'(coefs[k]);
      end
      @(negedge clk);
      coef_we = 0;
   endtask

   task automatic producer(int w, int h, int seed, int mode);
      int np = 0;
      for (int s = 0; s*W <= w-K; s++) begin
         int sw = (w - s*W > W+K-1) ? W+K-1 : w - s*W;
         for (int r = 0; r < h; r++) begin
            int row = (s % 2 == 0) ? r : h-1-r;
            for (int c = 0; c < sw; c++) begin
               if ((np % 5) == 3) begin
                  in_valid = 0;
                  @(negedge clk);
               end
               in_valid = 1;
               in_pix = 8'(pixv(s*W+c, row, seed, mode));
               while (!in_ready) @(negedge clk);
               @(negedge clk);
               np++;
            end
         end
      end
      in_valid = 0;
   endtask

   task automatic consumer(int w, int h, int seed, int mode);
      int n = 0;
      for (int s = 0; s*W <= w-K; s++) begin
         int sw = (w - s*W > W+K-1) ? W+K-1 : w - s*W;
         for (int r = K; r <= h; r++) begin
            int ey = (s % 2 == 0) ? r-K : h-r;
            for (int xo = 0; xo <= sw-K; xo++) begin
               int ex = s*W + xo;
               int cas = ((n*7) % 50) - 25;
               int esum = cas;
               int got_sum;
               bit got = 0;
               for (int i = 0; i < K; i++)
                  for (int j = 0; j < K; j++)
                     esum += coefs[i*K+j] * pixv(ex+j, ey+i, seed, mode);
               while (!got) begin
                  @(negedge clk);
                  out_ready = ((cyc*5 + seed) % 7) != 0;
                  cas_in = RES_W'(cas);
                  #1;
                  if (out_valid && out_ready) got = 1;
               end
               got_sum = int'($signed(out_sum));
               check(int'(out_x) == ex, "R5 out_x", int'(out_x), ex);
               check(int'(out_y) == ey, "R5 out_y", int'(out_y), ey);
               check(got_sum == esum, "R4 out_sum", got_sum, esum);
               n++;
            end
         end
      end
      @(negedge clk);
      out_ready = 0;
   endtask

   task automatic disturber();
      repeat (25) @(negedge clk);
      coef_we = 1; coef_addr = 0; coef_data = 8'h7f;  // R8 write while busy
      start = 1; img_w = 10'd3; img_h = 10'd3;          // R9 start while busy
      @(negedge clk);
      coef_we = 0; start = 0;
   endtask

   task automatic run_frame(int w, int h, int seed, int mode, bit disturb);
      load_coefs(seed, mode);
      @(negedge clk);
      img_w = DIM_W'(w); img_h = DIM_W'(h); start = 1;
      @(negedge clk);
      start = 0;
      check(in_ready == 1, "R2 in_ready after start", int'(in_ready), 1);
      fork
         producer(w, h, seed, mode);
         consumer(w, h, seed, mode);
         if (disturb) disturber();
      join
      // R3: all pixels were taken and the block has no more results pending
      check(in_ready == 0 && out_valid == 0, "R10 idle after frame",
            int'({in_ready, out_valid}), 0);
      check(in_valid == 0, "R3 producer completed", int'(in_valid), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(in_ready == 0, "R1 in_ready in reset", int'(in_ready), 0);
      check(out_valid == 0, "R1 out_valid in reset", int'(out_valid), 0);
      rst_n = 1;
      @(negedge clk);
      check(in_ready == 0 && out_valid == 0, "R1 idle after reset",
            int'({in_ready, out_valid}), 0);
      run_frame(3, 3, 1, 0, 0);
      run_frame(5, 4, 2, 0, 0);
      run_frame(6, 5, 3, 0, 0);
      run_frame(7, 6, 4, 0, 0);
      run_frame(9, 5, 5, 0, 0);
      run_frame(10, 7, 6, 0, 1);   // R8, R9 disturbance during frame
      run_frame(13, 4, 7, 0, 0);
      run_frame(8, 3, 8, 0, 0);
      run_frame(6, 4, 9, 1, 0);    // extreme negative accumulation, R4
      run_frame(4, 3, 10, 0, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule